// File: doc/BRIEF.md
# Register-File LIFO Stack

This block is a synchronous last-in, first-out store built from a small array of registers. A single pointer register always names the word on top of the stack. A push first advances the pointer and then writes the input word at the new address. A pop copies the top word to a registered data output and then moves the pointer back.

Two status flags show whether the stack is full or empty. Both are derived from the pointer returning to zero, so the block needs no separate occupancy counter. On the push that fills the stack, the pointer wraps to zero, which means address zero holds the most recent item. A request that cannot be served changes no state and pulses an error output for one cycle. Three cases count as such a request: a push while full, a pop while empty, and a push and pop in the same cycle.

Top module: `lifo_regstack`

## Requirements
- R1: After reset, the pointer is 0, the empty flag is 1, the full flag is 0, the error output is 0 and the data output is 0.
- R2: The full and empty flags are never high together, and either flag being high implies that the pointer is 0.
- R3: An accepted push (push only, not full) sets the pointer to its old value plus one, modulo 64. It writes the input word at that new address and clears the empty flag, all visible one cycle later.
- R4: The full flag rises on the push that takes the pointer from 63 to 0, which is the 64th push from empty. The next pop then returns that last-pushed word, which is stored at address 0.
- R5: An accepted pop (pop only, not empty) loads the word at the current pointer into the data output and decrements the pointer, modulo 64. It clears the full flag, and it sets the empty flag when the new pointer is 0.
- R6: Words come out in the reverse of their push order, for any interleaving of accepted pushes and pops.
- R7: A push while full changes neither the pointer, the flags, the data output nor the stored words. The error output is 1 in the following cycle only.
- R8: A pop while empty leaves the data output, the pointer and both flags unchanged. The error output is 1 in the following cycle only.
- R9: A push and a pop requested in the same cycle change no state, and the error output is 1 in the following cycle.
- R10: The data output keeps its value in every cycle without an accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| din_i | input | DW | Word to push |
| dout_o | output | DW | Last popped word (registered) |
| top_o | output | AW | Stack pointer, address of the top word |
| full_o | output | 1 | Stack holds 64 words |
| empty_o | output | 1 | Stack holds no words |
| err_o | output | 1 | One-cycle pulse after a rejected request |

## Verification
Assertions check the following on every cycle: the pointer step on each accepted push and pop, the exclusion between the flags and their tie to a zero pointer, the frozen state and error pulse after a push-and-pop clash, and the error pulse after a push while full. Only the bench scenarios can show the rest. These are that words return in reverse order, that the wrap pushes the last item into address 0, and that rejected pushes leave the stored contents untouched. The bench shows these by comparing full fill-and-drain sweeps and interleaved traffic against a queue model.

// File: rtl/lifo_regstack.sv
module lifo_regstack #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic [AW-1:0] top_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] sp_q;
  logic          full_q, empty_q, err_q;
  logic [DW-1:0] dout_q;

  wire clash    = push_i & pop_i;
  wire do_push  = push_i & ~pop_i & ~full_q;
  wire do_pop   = pop_i & ~push_i & ~empty_q;
  wire reject   = clash | (push_i & full_q) | (pop_i & empty_q);
  wire [AW-1:0] sp_up = sp_q + 1'b1;
  wire [AW-1:0] sp_dn = sp_q - 1'b1;

  always_ff @(posedge clk)
    if (do_push) mem[sp_up] <= din_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
      dout_q  <= '0;
    end else begin
      err_q <= reject;
      if (do_push) begin
        sp_q    <= sp_up;
        full_q  <= (sp_up == '0);
        empty_q <= 1'b0;
      end else if (do_pop) begin
        dout_q  <= mem[sp_q];
        sp_q    <= sp_dn;
        full_q  <= 1'b0;
        empty_q <= (sp_dn == '0);
      end
    end
  end

  assign dout_o  = dout_q;
  assign top_o   = sp_q;
  assign full_o  = full_q;
  assign empty_o = empty_q;
  assign err_o   = err_q;
endmodule

// File: rtl/lifo_regstack_chk.sv
module lifo_regstack_chk #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic [DW-1:0] dout_o,
  input logic [AW-1:0] top_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          err_o
);
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (top_o == AW'($past(top_o) + 1'b1)) && !empty_o); // R3
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> (top_o == AW'($past(top_o) - 1'b1)) && !full_o); // R5
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o)); // R2
  AST_FLAG_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o || empty_o) |-> (top_o == '0)); // R2
  AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> err_o && full_o && $stable(top_o) && $stable(dout_o)); // R7
  AST_EMPTY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> err_o && empty_o && $stable(top_o) && $stable(dout_o)); // R8
  AST_CLASH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> err_o && $stable(top_o) && $stable(full_o) && $stable(empty_o) && $stable(dout_o)); // R9
endmodule

bind lifo_regstack lifo_regstack_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .dout_o(dout_o),
  .top_o(top_o), .full_o(full_o), .empty_o(empty_o), .err_o(err_o));

// File: tb/tb_lifo_regstack.sv
module tb_lifo_regstack;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_i = 1'b0, pop_i = 1'b0;
  logic [7:0] din_i = '0;
  logic [7:0] dout_o;
  logic [5:0] top_o;
  logic full_o, empty_o, err_o;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] model[$];
  logic [7:0] exp_dout = '0;

  always #10 clk = ~clk;

  lifo_regstack #(.DW(8), .AW(6)) dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .din_i(din_i),
    .dout_o(dout_o), .top_o(top_o), .full_o(full_o), .empty_o(empty_o), .err_o(err_o));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic op(input bit pu, input bit po, input logic [7:0] d);
    string tag;
    bit bad;
    int n = model.size();
    bad = (pu && po) || (pu && !po && n == 64) || (po && !pu && n == 0);
    if (pu && po) tag = "R9";
    else if (pu && n == 64) tag = "R7";
    else if (po && n == 0) tag = "R8";
    else if (pu) tag = (n == 63) ? "R4" : "R3";
    else if (po) tag = "R6";
    else tag = "R10";
    if (!bad && pu) model.push_back(d);
    if (!bad && po) exp_dout = model.pop_back();
    push_i = pu; pop_i = po; din_i = d;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
    n = model.size();
    chk({tag, " ptr"}, top_o, n % 64);
    chk({tag, " full"}, full_o, n == 64);
    chk({tag, " empty"}, empty_o, n == 0);
    chk({tag, " err"}, err_o, bad);
    chk({tag, " dout"}, dout_o, exp_dout);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 ptr", top_o, 0);
    chk("R1 empty", empty_o, 1);
    chk("R1 full", full_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 dout", dout_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    op(0, 1, 8'h00);
    op(0, 0, 8'h00);
    chk("R8 err single pulse", err_o, 0);
    op(1, 1, 8'h11);
    for (int pass = 0; pass < 3; pass++) begin
      for (int i = 0; i < 64; i++) op(1, 0, 8'((i * 37 + pass * 11 + 5)));
      op(1, 0, 8'hEE);
      op(0, 0, 8'h00);
      chk("R7 err single pulse", err_o, 0);
      op(1, 1, 8'h22);
      op(0, 1, 8'h00);
      chk("R4 address 0 holds last push", dout_o, 8'((63 * 37 + pass * 11 + 5)));
      for (int i = 0; i < 63; i++) op(0, 1, 8'h00);
      op(0, 1, 8'h00);
      op(0, 0, 8'h00);
    end
    for (int i = 0; i < 400; i++) begin
      int k = (i * 7 + 3) % 10;
      op(k < 6, k >= 6 && k < 9, 8'((i * 13 + 1)));
    end
    for (int i = 0; i < 70; i++) op(0, 1, 8'h00);
    op(0, 0, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule